// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block produces the column address for every beat of a synchronous DRAM burst. A start pulse captures a start column together with a burst length code, a wrap order and a column-width select. From that edge on, the block presents one column per clock, with a valid flag, until the burst ends. The final beat of the burst carries a done flag.

Fixed bursts of 1, 2, 4 or 8 beats wrap inside an aligned block of that size. The order inside the block is either linear or interleaved, where the beat index is XORed into the low bits. A full-page burst walks the whole row modulo the selected column width. It keeps going until a stop input ends it.

A new start may arrive on any clock. It drops the burst in progress and restarts from the new column. The block deals only with column sequencing. Data, rows and banks are handled elsewhere.

Top module: `sdram_col_seq`

## Requirements
- R1: On a clock edge with start_i high, the next outputs show beat 0: valid_o=1 and col_o equal to start_col_i with the bits above the selected width cleared. No beat appears without a start.
- R2: burst_len_i codes 0,1,2,3 select 1,2,4,8 beats. done_o is high only on the last beat. One cycle after that beat, valid_o and done_o are both 0.
- R3: With wrap_mode_i=0 (linear), beat n holds the start column's upper bits fixed. Its low log2(L) bits equal (start+n) mod L.
- R4: With wrap_mode_i=1 (interleaved) and a fixed length L, beat n equals the start column with its low log2(L) bits XORed with n.
- R5: burst_len_i=7 selects full page: the column increments modulo 2^width without end. stop_i high at an edge during such a burst makes the next beat the last (done_o=1). stop_i has no effect during fixed bursts or when idle.
- R6: For a full-page burst, wrap_mode_i=1 is ignored and the order is linear.
- R7: width_sel_i=0,1,2 select 10,9,8 column bits, and 3 acts as 2. col_o bits above the width are always 0, and full-page bursts wrap at 2^width.
- R8: A start during a burst aborts it at that edge. The new burst begins, and starts on consecutive clocks each produce a fresh beat 0.
- R9: After reset, valid_o=0, done_o=0 and col_o=0.
- R10: Reserved length codes 4, 5 and 6 act as a single-beat burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst at this edge |
| start_col_i | input | 10 | Starting column |
| burst_len_i | input | 3 | Length code: 0=1, 1=2, 2=4, 3=8, 7=full page |
| wrap_mode_i | input | 1 | 0 linear, 1 interleaved |
| width_sel_i | input | 2 | Column width: 0=10, 1=9, 2/3=8 bits |
| stop_i | input | 1 | Ends a full-page burst |
| col_o | output | 10 | Column of the current beat |
| valid_o | output | 1 | A beat is presented |
| done_o | output | 1 | Current beat is the last |

## Verification
The hardest case to reach is a full-page burst that has already wrapped past its start column before it is stopped. Only there do the modulo-width wrap and the stop-driven termination show together. The stimulus selects the 8-bit width so that the wrap occurs after 256 beats. It runs a few beats beyond the wrap and then raises stop between edges. Aborts are placed mid-burst, and so are back-to-back starts, so that the restart path is taken while the counters hold non-zero state.

// File: rtl/sdram_col_seq_pkg.sv
package sdram_col_seq_pkg;

  typedef enum logic [2:0] {
    BL_1    = 3'd0,
    BL_2    = 3'd1,
    BL_4    = 3'd2,
    BL_8    = 3'd3,
    BL_PAGE = 3'd7
  } burst_len_e;

  typedef enum logic {
    WRAP_LIN  = 1'b0,
    WRAP_INTL = 1'b1
  } wrap_e;

  typedef struct packed {
    logic full;
    logic intl;
    logic single;
  } cfg_flags_t;

endpackage

// File: rtl/sdram_col_cfg.sv
module sdram_col_cfg
  import sdram_col_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int WSEL_W     = 2,
  parameter int NARROW_MAX = 2
) (
  input  logic [2:0]        len_code_i,
  input  logic              wrap_i,
  input  logic [WSEL_W-1:0] wsel_i,
  output logic [COL_W-1:0]  burst_mask_o,
  output logic [COL_W-1:0]  width_mask_o,
  output cfg_flags_t        flags_o
);

  localparam logic [WSEL_W-1:0] NARROW_LIM = WSEL_W'(NARROW_MAX);

  logic [WSEL_W-1:0] narrow;
  logic              full;

  always_comb begin
    narrow       = (wsel_i > NARROW_LIM) ? NARROW_LIM : wsel_i;
    width_mask_o = {COL_W{1'b1}} >> narrow;
  end

  always_comb begin
    full = 1'b0;
    case (len_code_i)
      BL_2:    burst_mask_o = COL_W'(1);
      BL_4:    burst_mask_o = COL_W'(3);
      BL_8:    burst_mask_o = COL_W'(7);
      BL_PAGE: begin
        burst_mask_o = width_mask_o;
        full         = 1'b1;
      end
      default: burst_mask_o = '0;  // BL_1 and reserved codes
    endcase
  end

  always_comb begin
    flags_o.full   = full;
    flags_o.intl   = (wrap_i == WRAP_INTL) && !full;
    flags_o.single = (burst_mask_o == '0);
  end

endmodule

// File: rtl/sdram_col_gen.sv
module sdram_col_gen #(
  parameter int COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] beat_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             intl_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;

  assign sum = base_i + beat_i;

  // Per bit: outside mask keep base, inside pick linear or XOR order
  for (genvar b = 0; b < COL_W; b++) begin : g_bit
    assign col_o[b] = mask_i[b] ? (intl_i ? (base_i[b] ^ beat_i[b]) : sum[b])
                                : base_i[b];
  end

endmodule

// File: rtl/sdram_col_ctrl.sv
module sdram_col_ctrl
  import sdram_col_seq_pkg::*;
#(
  parameter int COL_W = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic             stop_i,
  input  logic [COL_W-1:0] burst_mask_i,
  input  cfg_flags_t       flags_i,
  input  logic [COL_W-1:0] next_col_i,
  output logic [COL_W-1:0] base_o,
  output logic [COL_W-1:0] beat_nxt_o,
  output logic [COL_W-1:0] mask_o,
  output logic             intl_o,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             done_o
);

  logic [COL_W-1:0] base_q, beat_q, mask_q, col_q;
  logic             intl_q, full_q, valid_q, done_q;
  logic [COL_W-1:0] beat_nxt;

  assign beat_nxt = beat_q + COL_W'(1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q  <= '0;
      beat_q  <= '0;
      mask_q  <= '0;
      col_q   <= '0;
      intl_q  <= 1'b0;
      full_q  <= 1'b0;
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else if (start_i) begin
      base_q  <= start_col_i;
      beat_q  <= '0;
      mask_q  <= burst_mask_i;
      intl_q  <= flags_i.intl;
      full_q  <= flags_i.full;
      col_q   <= start_col_i;
      valid_q <= 1'b1;
      done_q  <= flags_i.single;
    end else if (valid_q && !done_q) begin
      beat_q  <= beat_nxt;
      col_q   <= next_col_i;
      done_q  <= full_q ? stop_i : (beat_nxt == mask_q);
    end else if (done_q) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end
  end

  assign base_o     = base_q;
  assign beat_nxt_o = beat_nxt;
  assign mask_o     = mask_q;
  assign intl_o     = intl_q;
  assign col_o      = col_q;
  assign valid_o    = valid_q;
  assign done_o     = done_q;

endmodule

// File: rtl/sdram_col_seq.sv
module sdram_col_seq
  import sdram_col_seq_pkg::*;
#(
  parameter int COL_W      = 10,
  parameter int WSEL_W     = 2,
  parameter int NARROW_MAX = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [COL_W-1:0]  start_col_i,
  input  logic [2:0]        burst_len_i,
  input  logic              wrap_mode_i,
  input  logic [WSEL_W-1:0] width_sel_i,
  input  logic              stop_i,
  output logic [COL_W-1:0]  col_o,
  output logic              valid_o,
  output logic              done_o
);

  logic [COL_W-1:0] burst_mask, width_mask, start_col_m;
  logic [COL_W-1:0] base, beat_nxt, mask_q, next_col;
  logic             intl_q;
  cfg_flags_t       flags;

  sdram_col_cfg #(
    .COL_W      (COL_W),
    .WSEL_W     (WSEL_W),
    .NARROW_MAX (NARROW_MAX)
  ) u_cfg (
    .len_code_i   (burst_len_i),
    .wrap_i       (wrap_mode_i),
    .wsel_i       (width_sel_i),
    .burst_mask_o (burst_mask),
    .width_mask_o (width_mask),
    .flags_o      (flags)
  );

  assign start_col_m = start_col_i & width_mask;

  sdram_col_ctrl #(
    .COL_W (COL_W)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .start_col_i  (start_col_m),
    .stop_i       (stop_i),
    .burst_mask_i (burst_mask),
    .flags_i      (flags),
    .next_col_i   (next_col),
    .base_o       (base),
    .beat_nxt_o   (beat_nxt),
    .mask_o       (mask_q),
    .intl_o       (intl_q),
    .col_o        (col_o),
    .valid_o      (valid_o),
    .done_o       (done_o)
  );

  sdram_col_gen #(
    .COL_W (COL_W)
  ) u_gen (
    .base_i (base),
    .beat_i (beat_nxt),
    .mask_i (mask_q),
    .intl_i (intl_q),
    .col_o  (next_col)
  );

endmodule

// File: rtl/sdram_col_seq_chk.sv
module sdram_col_seq_chk #(
  parameter int COL_W      = 10,
  parameter int WSEL_W     = 2,
  parameter int NARROW_MAX = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic [COL_W-1:0]  start_col_i,
  input logic [2:0]        burst_len_i,
  input logic              wrap_mode_i,
  input logic [WSEL_W-1:0] width_sel_i,
  input logic              stop_i,
  input logic [COL_W-1:0]  col_o,
  input logic              valid_o,
  input logic              done_o
);

  logic [COL_W-1:0] ck_wmask, wmask_in;
  logic             ck_full;

  always_comb begin
    if (int'(width_sel_i) >= NARROW_MAX) wmask_in = {COL_W{1'b1}} >> NARROW_MAX;
    else                                 wmask_in = {COL_W{1'b1}} >> width_sel_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ck_wmask <= {COL_W{1'b1}};
      ck_full  <= 1'b0;
    end else if (start_i) begin
      ck_wmask <= wmask_in;
      ck_full  <= (burst_len_i == 3'd7);
    end
  end

  AST_START_LOADS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o && (col_o == ($past(start_col_i) & ck_wmask)));  // R1
  AST_NO_SPONTANEOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o && !start_i |=> !valid_o);  // R1
  AST_DONE_HAS_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> valid_o);  // R2
  AST_DONE_ENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> !valid_o && !done_o);  // R2
  AST_STOP_ENDS_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_o && ck_full && stop_i && !start_i |=> done_o);  // R5
  AST_PAGE_RUNS_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !done_o && ck_full && !stop_i && !start_i |=> valid_o && !done_o);  // R5
  AST_COL_IN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((col_o & ~ck_wmask) == '0));  // R7

endmodule

bind sdram_col_seq sdram_col_seq_chk #(
  .COL_W      (COL_W),
  .WSEL_W     (WSEL_W),
  .NARROW_MAX (NARROW_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .start_col_i (start_col_i),
  .burst_len_i (burst_len_i),
  .wrap_mode_i (wrap_mode_i),
  .width_sel_i (width_sel_i),
  .stop_i      (stop_i),
  .col_o       (col_o),
  .valid_o     (valid_o),
  .done_o      (done_o)
);

// File: tb/sdram_col_seq_tb_top.sv
`timescale 1ns/1ps
module sdram_col_seq_tb_top;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       start_i = 1'b0;
  logic [9:0] start_col_i = '0;
  logic [2:0] burst_len_i = '0;
  logic       wrap_mode_i = 1'b0;
  logic [1:0] width_sel_i = '0;
  logic       stop_i = 1'b0;
  logic [9:0] col_o;
  logic       valid_o, done_o;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  sdram_col_seq dut_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .start_col_i (start_col_i),
    .burst_len_i (burst_len_i),
    .wrap_mode_i (wrap_mode_i),
    .width_sel_i (width_sel_i),
    .stop_i      (stop_i),
    .col_o       (col_o),
    .valid_o     (valid_o),
    .done_o      (done_o)
  );

  function automatic int width_of(int ws);
    return (ws == 0) ? 10 : (ws == 1) ? 9 : 8;
  endfunction

  function automatic int len_of(int lc, int ws);
    if (lc == 7) return 1 << width_of(ws);
    if (lc <= 3) return 1 << lc;
    return 1;
  endfunction

  function automatic int exp_col(int s, int n, int lc, int wr, int ws);
    int wm, sm, m;
    wm = (1 << width_of(ws)) - 1;
    sm = s & wm;
    m  = len_of(lc, ws) - 1;
    if (wr != 0 && lc != 7) return (sm & ~m) | ((sm ^ n) & m);
    return (sm & ~m) | ((sm + n) & m);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_start(int s, int lc, int wr, int ws);
    @(negedge clk_i);
    start_i = 1'b1; start_col_i = 10'(s); burst_len_i = 3'(lc);
    wrap_mode_i = wr[0]; width_sel_i = 2'(ws);
    @(posedge clk_i); #1;
    start_i = 1'b0;
  endtask

  // beat 0 already visible on entry
  task automatic run_checks(int s, int lc, int wr, int ws, string req);
    int len;
    len = len_of(lc, ws);
    for (int n = 0; n < len; n++) begin
      if (n > 0) begin @(posedge clk_i); #1; end
      chk(req, "col", int'(col_o), exp_col(s, n, lc, wr, ws));
      chk(req, "valid", int'(valid_o), 1);
      chk(req, "done", int'(done_o), (n == len - 1) ? 1 : 0);
    end
    @(posedge clk_i); #1;
    chk(req, "valid after end", int'(valid_o), 0);
    chk(req, "done after end", int'(done_o), 0);
  endtask

  task automatic t_reset();
    chk("R9", "valid", int'(valid_o), 0);
    chk("R9", "done", int'(done_o), 0);
    chk("R9", "col", int'(col_o), 0);
  endtask

  task automatic t_fixed(int s, int lc, int wr, int ws, string req);
    do_start(s, lc, wr, ws);
    run_checks(s, lc, wr, ws, req);
  endtask

  task automatic t_full(int s, int wr, int ws, int extra, string req);
    int nb;
    nb = (1 << width_of(ws)) + extra;
    do_start(s, 7, wr, ws);
    for (int n = 0; n < nb; n++) begin
      if (n > 0) begin @(posedge clk_i); #1; end
      chk(req, "page col", int'(col_o), exp_col(s, n, 7, wr, ws));
      chk(req, "page done", int'(done_o), 0);
    end
    stop_i = 1'b1;
    @(posedge clk_i); #1;
    stop_i = 1'b0;
    chk("R5", "stop beat col", int'(col_o), exp_col(s, nb, 7, wr, ws));
    chk("R5", "stop beat done", int'(done_o), 1);
    @(posedge clk_i); #1;
    chk("R5", "valid after stop", int'(valid_o), 0);
  endtask

  task automatic t_stop_ignored();
    stop_i = 1'b1;
    do_start(10'h0a3, 3, 0, 0);
    run_checks(10'h0a3, 3, 0, 0, "R5");
    @(posedge clk_i); #1;
    chk("R5", "idle stop no beat", int'(valid_o), 0);
    stop_i = 1'b0;
  endtask

  task automatic t_abort();
    do_start(10'h012, 3, 0, 0);
    for (int n = 0; n < 3; n++) begin
      if (n > 0) begin @(posedge clk_i); #1; end
      chk("R8", "pre-abort col", int'(col_o), exp_col(10'h012, n, 3, 0, 0));
    end
    do_start(10'h2c5, 2, 1, 0);
    run_checks(10'h2c5, 2, 1, 0, "R8");
  endtask

  task automatic t_back2back();
    int cols[5] = '{10'h100, 10'h0ff, 10'h3f3, 10'h051, 10'h2aa};
    for (int i = 0; i < 5; i++) begin
      do_start(cols[i], 3, i % 2, 0);
      chk("R8", "b2b col", int'(col_o), cols[i]);
      chk("R8", "b2b valid", int'(valid_o), 1);
      chk("R8", "b2b done", int'(done_o), 0);
    end
    run_checks(10'h2aa, 3, 0, 0, "R8");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1 t_reset();
    repeat (3) @(posedge clk_i);
    #1 t_reset();
    @(negedge clk_i) rst_ni = 1'b1;
    @(posedge clk_i); #1;
    chk("R1", "no beat before start", int'(valid_o), 0);

    t_fixed(10'h155, 0, 0, 0, "R2");
    t_fixed(10'h155, 1, 0, 0, "R2");
    t_fixed(10'h156, 2, 0, 0, "R3");
    t_fixed(10'h23d, 3, 0, 0, "R3");
    t_fixed(10'h23d, 3, 1, 0, "R4");
    t_fixed(10'h2c5, 2, 1, 0, "R4");
    t_fixed(10'h3ff, 3, 0, 1, "R7");
    t_fixed(10'h3fe, 1, 1, 3, "R7");
    t_fixed(10'h3ff, 0, 0, 2, "R1");
    t_fixed(10'h077, 4, 1, 0, "R10");
    t_fixed(10'h078, 6, 0, 0, "R10");
    t_full(10'h3f9, 0, 2, 5, "R7");
    t_full(10'h1fd, 1, 2, 9, "R6");
    t_full(10'h003, 0, 0, -1015, "R5");
    t_stop_ignored();
    t_abort();
    t_back2back();

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule